// File: doc/BRIEF.md
# Power-on reset timeout sequencer

This block holds a processor core in reset after power-on until the clocks it depends on can be trusted. It can run up to three timeouts, always in the same order. The first is a power-up delay counted on a slow internal clock. The second is an oscillator start-up count on the external oscillator input. The third is a PLL lock wait measured in reference ticks. Each stage is enabled or skipped according to the selected oscillator mode, a power-up-delay enable, and the kind of reset event.

Every timeout is measured from the end of the power-on pulse. The external master-clear pin only gates the core-reset output and never restarts a count. Holding master-clear low until all stages have expired therefore lets the core start as soon as the pin is released.

A wake event is given after a low-power state that stopped the external oscillator. It re-runs the oscillator and PLL stages, but not the power-up delay.

Top module: `por_timeout_seq`

## Requirements
- R1: While `rst_ni` (the power-on pulse, active low) is low, `core_rst_o` is 1.
- R2: When `pwrt_en_ni` is 0, a power-up delay of `PWRT_CYCLES` (2048) `slow_clk_i` periods runs first after `rst_ni` rises, and `core_rst_o` stays 1 throughout it.
- R3: When `pwrt_en_ni` is 1, the power-up delay is skipped.
- R4: In the crystal modes (`osc_mode_i` 0 = low-power crystal, 1 = crystal, 2 = fast crystal, 3 = fast crystal with PLL), a start-up count of `OST_CYCLES` (1024) `osc_clk_i` cycles follows the power-up delay and holds `core_rst_o` at 1.
- R5: In modes 4 (external clock), 5 (RC), 6 and 7 (internal oscillator), the oscillator start-up count is skipped.
- R6: In mode 3 only, a lock wait of `PLL_TICKS` `pll_tick_i` pulses follows the oscillator start-up count and keeps `core_rst_o` at 1.
- R7: In mode 5 with `pwrt_en_ni` = 1, `core_rst_o` falls within 4 `clk_i` cycles after `rst_ni` rises.
- R8: `mclr_ni` low forces `core_rst_o` to 1 within 4 `clk_i` cycles. The timeouts run regardless of `mclr_ni`. Once they have expired, raising `mclr_ni` lets `core_rst_o` fall within 4 cycles.
- R9: A one-cycle `wake_i` pulse while the core runs in a crystal mode sets `core_rst_o` to 1 two cycles later. It then re-runs the oscillator start-up count, plus the lock wait in mode 3, without the power-up delay.
- R10: `wake_i` has no effect in modes 4 to 7, and it has no effect while a timeout sequence is still running.
- R11: At most one stage is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; the sequencer and the output register run on it |
| rst_ni | input | 1 | Power-on pulse, active low, asynchronous |
| slow_clk_i | input | 1 | Slow internal clock for the power-up delay |
| osc_clk_i | input | 1 | External oscillator input for the start-up count |
| pll_tick_i | input | 1 | One-cycle reference tick in the `clk_i` domain for the lock wait |
| mclr_ni | input | 1 | External master-clear pin, active low |
| osc_mode_i | input | 3 | Oscillator mode selection (encoding in R4/R5) |
| pwrt_en_ni | input | 1 | Power-up delay enable, active low |
| wake_i | input | 1 | Wake from a low-power state that stopped the oscillator, `clk_i` domain |
| core_rst_o | output | 1 | Core reset, active high, synchronous to `clk_i` |

## Verification
The hardest case to reach is a second oscillator start-up run after a wake. The start-up stage's done flag comes back from the oscillator domain and still holds its old value when the wake arrives. The sequencer has to see that flag clear before it re-arms the stage; otherwise it would release the core at once. The stimulus first completes a full power-on sequence in a crystal mode, then pulses `wake_i` and checks that the release comes a full start-up count later. It also pulses `wake_i` partway through a power-up delay, and holds master-clear low across a complete sequence in PLL mode.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
  localparam logic [2:0] MODE_XTAL_LOW  = 3'd0;
  localparam logic [2:0] MODE_XTAL      = 3'd1;
  localparam logic [2:0] MODE_XTAL_FAST = 3'd2;
  localparam logic [2:0] MODE_XTAL_PLL  = 3'd3;
  localparam logic [2:0] MODE_EXT_CLK   = 3'd4;
  localparam logic [2:0] MODE_RC        = 3'd5;
  localparam logic [2:0] MODE_INT_OSC   = 3'd6;

  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_PWRUP = 3'd1,
    ST_XCLR  = 3'd2,
    ST_XTAL  = 3'd3,
    ST_LOCK  = 3'd4,
    ST_RUN   = 3'd5
  } seq_st_e;

  function automatic logic mode_has_xtal(input logic [2:0] mode);
    return mode <= MODE_XTAL_PLL;
  endfunction
endpackage

// File: rtl/por_sync2.sv
module por_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/por_stage_cnt.sv
// Timeout stage in its own clock domain: counts while the synced request is high,
// holds done until the request drops.
module por_stage_cnt #(
  parameter int unsigned CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic          req_s;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  por_sync2 #(.RST_VAL(1'b0)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!req_s) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CW'(CYCLES - 1)) done_q <= 1'b1;
      else                          cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
  import por_seq_pkg::*;
#(
  parameter int unsigned PLL_TICKS = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] osc_mode_i,
  input  logic       pwrt_en_ni,
  input  logic       wake_i,
  input  logic       pll_tick_i,
  input  logic       pwrt_done_i,
  input  logic       ost_done_i,
  output logic       pwrt_req_o,
  output logic       ost_req_o,
  output logic       pll_act_o,
  output logic       run_o
);
  localparam int unsigned LW = (PLL_TICKS > 1) ? $clog2(PLL_TICKS) : 1;

  seq_st_e       st_q, st_d;
  logic [LW-1:0] lock_cnt_q;
  logic          has_x;

  assign has_x = mode_has_xtal(osc_mode_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_BOOT: begin
        if (!pwrt_en_ni) st_d = ST_PWRUP;
        else if (has_x)  st_d = ST_XCLR;
        else             st_d = ST_RUN;
      end
      ST_PWRUP: if (pwrt_done_i) st_d = has_x ? ST_XCLR : ST_RUN;
      // wait for a stale done from an earlier run to clear
      ST_XCLR:  if (!ost_done_i) st_d = ST_XTAL;
      ST_XTAL:  if (ost_done_i) st_d = (osc_mode_i == MODE_XTAL_PLL) ? ST_LOCK : ST_RUN;
      ST_LOCK:  if (pll_tick_i && lock_cnt_q == LW'(PLL_TICKS - 1)) st_d = ST_RUN;
      ST_RUN:   if (wake_i && has_x) st_d = ST_XCLR;
      default:  st_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_BOOT;
      lock_cnt_q <= '0;
      pwrt_req_o <= 1'b0;
      ost_req_o  <= 1'b0;
      pll_act_o  <= 1'b0;
    end else begin
      st_q       <= st_d;
      pwrt_req_o <= (st_d == ST_PWRUP);
      ost_req_o  <= (st_d == ST_XTAL);
      pll_act_o  <= (st_d == ST_LOCK);
      if (st_q != ST_LOCK)  lock_cnt_q <= '0;
      else if (pll_tick_i)  lock_cnt_q <= lock_cnt_q + 1'b1;
    end
  end

  assign run_o = (st_q == ST_RUN);
endmodule

// File: rtl/por_timeout_seq.sv
module por_timeout_seq #(
  parameter int unsigned PWRT_CYCLES = 2048,
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned PLL_TICKS   = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slow_clk_i,
  input  logic       osc_clk_i,
  input  logic       pll_tick_i,
  input  logic       mclr_ni,
  input  logic [2:0] osc_mode_i,
  input  logic       pwrt_en_ni,
  input  logic       wake_i,
  output logic       core_rst_o
);
  logic pwrt_req, ost_req, pll_act, run;
  logic pwrt_done, ost_done, pwrt_done_s, ost_done_s;
  logic mclr_s, core_rst_q;

  por_sync2 #(.RST_VAL(1'b0)) u_mclr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mclr_ni), .q_o(mclr_s)
  );

  por_stage_cnt #(.CYCLES(PWRT_CYCLES)) u_pwrt (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .req_i(pwrt_req), .done_o(pwrt_done)
  );

  por_stage_cnt #(.CYCLES(OST_CYCLES)) u_ost (
    .clk_i(osc_clk_i), .rst_ni(rst_ni), .req_i(ost_req), .done_o(ost_done)
  );

  por_sync2 #(.RST_VAL(1'b0)) u_pwrt_done_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwrt_done), .q_o(pwrt_done_s)
  );

  por_sync2 #(.RST_VAL(1'b0)) u_ost_done_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ost_done), .q_o(ost_done_s)
  );

  por_seq_fsm #(.PLL_TICKS(PLL_TICKS)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_mode_i (osc_mode_i),
    .pwrt_en_ni (pwrt_en_ni),
    .wake_i     (wake_i),
    .pll_tick_i (pll_tick_i),
    .pwrt_done_i(pwrt_done_s),
    .ost_done_i (ost_done_s),
    .pwrt_req_o (pwrt_req),
    .ost_req_o  (ost_req),
    .pll_act_o  (pll_act),
    .run_o      (run)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) core_rst_q <= 1'b1;
    else         core_rst_q <= !mclr_s || !run;
  end

  assign core_rst_o = core_rst_q;
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk
  import por_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mclr_ni,
  input logic       wake_i,
  input logic [2:0] osc_mode_i,
  input logic       core_rst_o,
  input logic       pwrt_req,
  input logic       ost_req,
  input logic       pll_act,
  input logic       run,
  input logic       ost_done_s
);
  // R8
  mclr_forces_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!mclr_ni, 3) |-> core_rst_o);

  // R11
  stage_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pwrt_req, ost_req, pll_act}));

  // R6
  lock_after_xtal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_act) |-> $past(ost_done_s));

  // R4
  xtal_mode_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ost_req) |-> mode_has_xtal(osc_mode_i));

  // R9
  wake_reasserts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && wake_i && mode_has_xtal(osc_mode_i)) |-> ##2 core_rst_o);
endmodule

bind por_timeout_seq por_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mclr_ni   (mclr_ni),
  .wake_i    (wake_i),
  .osc_mode_i(osc_mode_i),
  .core_rst_o(core_rst_o),
  .pwrt_req  (pwrt_req),
  .ost_req   (ost_req),
  .pll_act   (pll_act),
  .run       (run),
  .ost_done_s(ost_done_s)
);

// File: tb/por_timeout_seq_tb.sv
module por_timeout_seq_tb;
  localparam int TICKS = 20;
  localparam int PW = 2048 * 4;   // slow clock = 4 core cycles
  localparam int OW = 1024 * 2;   // osc clock  = 2 core cycles
  localparam int LW = TICKS * 4;  // tick every 4 core cycles
  localparam int SLACK_LO = 8;
  localparam int SLACK_HI = 80;

  logic clk_i = 0, slow_clk_i = 0, osc_clk_i = 0;
  logic rst_ni = 0, pll_tick_i = 0, mclr_ni = 1, pwrt_en_ni = 0, wake_i = 0;
  logic [2:0] osc_mode_i = 3'd4;
  logic core_rst_o;
  logic [1:0] tick_div = '0;

  always #10 clk_i = ~clk_i;
  always #40 slow_clk_i = ~slow_clk_i;
  always #20 osc_clk_i = ~osc_clk_i;

  always @(negedge clk_i) begin
    tick_div   <= tick_div + 2'd1;
    pll_tick_i <= (tick_div == 2'd3);
  end

  por_timeout_seq #(.PLL_TICKS(TICKS)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_clk_i(slow_clk_i), .osc_clk_i(osc_clk_i),
    .pll_tick_i(pll_tick_i), .mclr_ni(mclr_ni), .osc_mode_i(osc_mode_i),
    .pwrt_en_ni(pwrt_en_ni), .wake_i(wake_i), .core_rst_o(core_rst_o)
  );

  typedef struct { string req; int lo; int hi; } exp_t;
  exp_t sb_q[$];
  int   vectors = 0, miscompares = 0;
  bit   meas_req = 0, all_done = 0;

  task automatic chk(string req, int act, int lo, int hi);
    vectors++;
    if (act < lo || act > hi) begin
      miscompares++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // Monitor: hi==0 means core reset must stay low for 200 cycles;
  // otherwise measure cycles until core reset is seen high then low.
  initial begin
    exp_t e;
    int   n, rel;
    bit   seen;
    forever begin
      wait (meas_req);
      e = sb_q.pop_front();
      n = 0; rel = -1; seen = 0;
      if (e.hi == 0) begin
        for (int i = 0; i < 200; i++) begin
          @(negedge clk_i); n++;
          if (core_rst_o && rel < 0) rel = n;
        end
        chk(e.req, (rel < 0) ? 0 : rel, 0, 0);
      end else begin
        while (n < e.hi + 100) begin
          @(negedge clk_i); n++;
          if (core_rst_o) seen = 1;
          else if (seen) begin rel = n; break; end
        end
        chk(e.req, rel, e.lo, e.hi);
      end
      meas_req = 0;
    end
  end

  task automatic push_meas(string req, int lo, int hi);
    sb_q.push_back('{req, lo, hi});
    meas_req = 1;
  endtask

  task automatic wait_meas();
    wait (!meas_req);
  endtask

  task automatic por_start(logic [2:0] m, logic pn);
    @(negedge clk_i);
    rst_ni = 0; osc_mode_i = m; pwrt_en_ni = pn;
    repeat (5) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic run_case(string req, logic [2:0] m, logic pn, int nominal);
    por_start(m, pn);
    push_meas(req, (nominal > SLACK_LO) ? nominal - SLACK_LO : 1, nominal + SLACK_HI);
    wait_meas();
  endtask

  task automatic wake_case(string req, int nominal);
    @(negedge clk_i); wake_i = 1;
    push_meas(req, (nominal > SLACK_LO) ? nominal - SLACK_LO : 1, nominal + SLACK_HI);
    @(negedge clk_i); wake_i = 0;
    wait_meas();
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1", int'(core_rst_o), 1, 1);
    repeat (3) @(negedge clk_i);

    // R7: RC, no power-up delay
    por_start(3'd5, 1'b1);
    push_meas("R7", 1, 4);
    wait_meas();

    run_case("R2 ext-clk with power-up delay", 3'd4, 1'b0, PW);
    run_case("R5 internal osc with power-up delay", 3'd6, 1'b0, PW);
    run_case("R4 fast crystal with power-up delay", 3'd2, 1'b0, PW + OW);
    run_case("R6 PLL mode with power-up delay", 3'd3, 1'b0, PW + OW + LW);
    run_case("R3 fast crystal without power-up delay", 3'd2, 1'b1, OW);
    run_case("R3 low-power crystal without power-up delay", 3'd0, 1'b1, OW);
    run_case("R6 PLL mode without power-up delay", 3'd3, 1'b1, OW + LW);

    // R9: wake re-runs start-up count (crystal) and lock wait (PLL), no power-up delay
    por_start(3'd1, 1'b0);
    push_meas("R2 crystal boot", PW + OW - SLACK_LO, PW + OW + SLACK_HI);
    wait_meas();
    wake_case("R9 wake in crystal mode", OW);

    run_case("R6 PLL boot", 3'd3, 1'b1, OW + LW);
    wake_case("R9 wake in PLL mode", OW + LW);

    // R10: wake ignored in external-clock mode
    run_case("R2 ext-clk boot", 3'd4, 1'b0, PW);
    @(negedge clk_i); wake_i = 1;
    push_meas("R10 wake ignored in ext-clk mode", 0, 0);
    @(negedge clk_i); wake_i = 0;
    wait_meas();

    // R10: wake during a running sequence does not shorten or restart it
    por_start(3'd2, 1'b0);
    push_meas("R10 wake during power-up delay", PW + OW - SLACK_LO, PW + OW + SLACK_HI);
    repeat (100) @(negedge clk_i);
    wake_i = 1;
    @(negedge clk_i); wake_i = 0;
    wait_meas();

    // R8: master-clear held through all timeouts, then released
    @(negedge clk_i); mclr_ni = 0;
    por_start(3'd3, 1'b0);
    repeat (PW + OW + LW + 400) @(negedge clk_i);
    chk("R8 held by master-clear", int'(core_rst_o), 1, 1);
    @(negedge clk_i); mclr_ni = 1;
    push_meas("R8 release after master-clear", 2, 4);
    wait_meas();

    // R8: master-clear while running
    @(negedge clk_i); mclr_ni = 0;
    repeat (4) @(negedge clk_i);
    chk("R8 master-clear asserts reset", int'(core_rst_o), 1, 1);
    @(negedge clk_i); mclr_ni = 1;
    push_meas("R8 master-clear release in run", 2, 4);
    wait_meas();

    all_done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!all_done) begin
      miscompares++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule